// File: doc/BRIEF.md
# Conversion Sequencer for a Successive-Approximation Converter

This block is the digital side of a successive-approximation converter. Software writes a 5-bit control word together with a 3-bit clock-division code. From these the block derives a slow converter clock from the system clock and counts converter cycles for each conversion. It runs either one conversion per start command or a back-to-back stream of conversions. When a conversion finishes it captures a 10-bit sample, raises a completion flag, and can request an interrupt.

Channel and reference selections may be written at any time. They reach the analog front end only while the sequencer is idle or at the end of a conversion, so a conversion never sees its input switch part way through. The comparator and DAC are outside the block: the value on `sample_in` is taken as the conversion result on the cycle the conversion ends. A single acknowledge input stands in for interrupt vectoring.

Top module: `sar_seq_ctrl`

## Requirements
- R1: After synchronous reset every control bit is zero. The control readback (bit0 enable, bit1 busy, bit2 continuous, bit3 interrupt enable, bit4 completion flag) reads 0, and `irq`, `adc_clk`, `result`, `eff_chan` and `eff_ref` are all 0.
- R2: The division code written with the control word sets the number of system clocks per converter cycle as follows: 0 gives 2, 1 gives 2, 2 gives 4, 3 gives 8, 4 gives 16, 5 gives 32, 6 gives 64 and 7 gives 128.
- R3: The first conversion started after enabling lasts 25 converter cycles. This includes a start written (bit1 = 1) in the same write that sets enable (bit0 = 1). Every later conversion lasts 13.
- R4: Readback bit1 is one while a conversion runs and returns to zero when it ends. Writing bit1 = 0 while a conversion runs does not stop it.
- R5: In single mode (bit2 = 0), each write with bit0 = 1 and bit1 = 1 made while idle starts exactly one conversion. A start written while busy is ignored.
- R6: In continuous mode (bit2 = 1), one start is followed by back-to-back 13-cycle conversions. Clearing bit2 lets the running conversion finish and then the sequencer stops.
- R7: Writing bit0 = 0 aborts a running conversion at once. Busy drops on the next cycle, and neither the flag nor `result` is updated.
- R8: When a conversion completes, the flag (bit4) is set and `result` takes the value of `sample_in` on that cycle.
- R9: The flag clears when a control write has bit4 = 1 or when `irq_ack` is pulsed. A write with bit4 = 0 leaves the flag unchanged.
- R10: `irq` is high exactly when the flag, the interrupt-enable bit (bit3) and `gie` are all one.
- R11: A channel or reference value written during a conversion appears on `eff_chan`/`eff_ref` only after that conversion completes. When idle, it appears on the cycle after the write.
- R12: The divider counter is held at zero while the block is disabled (`adc_clk` stays 0) and starts from zero on enable. A conversion started together with the enable therefore lasts exactly 25 times the division ratio in system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 5 | Control write data: enable, start, continuous, interrupt enable, flag clear |
| ctl_div | input | 3 | Division code, captured with each control write |
| ctl_rdata | output | 5 | Control readback with busy and flag |
| sel_wr | input | 1 | Selection write strobe |
| sel_chan | input | 4 | Requested input channel |
| sel_ref | input | 2 | Requested reference |
| gie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Interrupt acknowledge, clears the flag |
| sample_in | input | 10 | Converter output sampled at end of conversion |
| adc_clk | output | 1 | Divided converter clock |
| eff_chan | output | 4 | Channel applied to the front end |
| eff_ref | output | 2 | Reference applied to the front end |
| result | output | 10 | Last completed conversion result |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is the 25-cycle first conversion whose start is not in the same write as the enable. Its length then depends on where the divider stands when the start arrives. The bench aborts a conversion, re-enables with no start, waits a few cycles and then starts, and accepts any length in the one-converter-cycle window this phase allows. Exact 25× and 13× lengths are measured where the divider phase is known: a start written together with the enable, and back-to-back continuous conversions timed between successive flag edges.

// File: rtl/sar_seq_pkg.sv
`timescale 1ns/1ps
package sar_seq_pkg;

    // division code width and the divider counter that covers the largest ratio
    localparam int DIV_W  = 3;
    localparam int PRE_W  = (1 << DIV_W) - 1;

    // control word layout
    localparam int CTL_W  = 5;
    localparam int B_EN   = 0;
    localparam int B_GO   = 1;
    localparam int B_LOOP = 2;
    localparam int B_IE   = 3;
    localparam int B_DONE = 4;

    // conversion lengths in converter cycles
    localparam int LEN_W  = 5;
    localparam logic [LEN_W-1:0] LEN_FIRST = LEN_W'(25);
    localparam logic [LEN_W-1:0] LEN_NORM  = LEN_W'(13);

    typedef enum logic {
        ENG_IDLE = 1'b0,
        ENG_RUN  = 1'b1
    } eng_state_e;

    typedef struct packed {
        logic             en;
        logic             loop;
        logic             ie;
        logic [DIV_W-1:0] div;
    } ctl_t;

    // system clocks per converter cycle for a division code
    function automatic logic [PRE_W:0] div_ratio(input logic [DIV_W-1:0] code);
        logic [PRE_W:0] r;
        r       = '0;
        r[code] = 1'b1;
        if (code == '0) r = (PRE_W+1)'(2);
        return r;
    endfunction

    function automatic logic [LEN_W-1:0] conv_len(input logic first);
        return first ? LEN_FIRST : LEN_NORM;
    endfunction

endpackage

// File: rtl/sar_seq_prescaler.sv
`timescale 1ns/1ps
module sar_seq_prescaler
    import sar_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div_sel,
    output logic             tick,
    output logic             adc_clk
);
    localparam logic [PRE_W:0]   ONE_X = (PRE_W+1)'(1);
    localparam logic [PRE_W-1:0] ONE_C = PRE_W'(1);

    logic [PRE_W-1:0] cnt_q;
    logic [PRE_W:0]   ratio;
    logic [PRE_W:0]   cnt_x;
    logic             wrap;

    assign ratio   = div_ratio(div_sel);
    assign cnt_x   = {1'b0, cnt_q};
    assign wrap    = cnt_x >= (ratio - ONE_X);
    assign tick    = run && wrap;
    assign adc_clk = run && (cnt_x >= (ratio >> 1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (wrap) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + ONE_C;
        end
    end
endmodule

// File: rtl/sar_seq_engine.sv
`timescale 1ns/1ps
module sar_seq_engine
    import sar_seq_pkg::*;
#(
    parameter int SMP_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_rise,
    input  logic             start_req,
    input  logic             abort,
    input  logic             loop,
    input  logic             tick,
    input  logic             flag_clr,
    input  logic [SMP_W-1:0] sample,
    output logic             busy,
    output logic             done,
    output logic             flag,
    output logic [SMP_W-1:0] result
);
    localparam logic [LEN_W-1:0] ONE_L = LEN_W'(1);

    eng_state_e       st_q;
    logic [LEN_W-1:0] cyc_q;
    logic [LEN_W-1:0] tgt_q;
    logic             init_q;
    logic             start_ok;
    logic             last;

    assign busy     = (st_q == ENG_RUN);
    assign last     = (cyc_q == (tgt_q - ONE_L));
    assign done     = busy && tick && last && !abort;
    assign start_ok = start_req && !busy && !abort;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ENG_IDLE;
            cyc_q  <= '0;
            tgt_q  <= '0;
            init_q <= 1'b0;
        end else begin
            if (en_rise) init_q <= 1'b1;
            if (abort) begin
                st_q  <= ENG_IDLE;
                cyc_q <= '0;
            end else if (start_ok) begin
                st_q   <= ENG_RUN;
                cyc_q  <= '0;
                tgt_q  <= conv_len(init_q || en_rise);
                init_q <= 1'b0;
            end else if (done) begin
                cyc_q <= '0;
                tgt_q <= LEN_NORM;
                st_q  <= loop ? ENG_RUN : ENG_IDLE;
            end else if (busy && tick) begin
                cyc_q <= cyc_q + ONE_L;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag   <= 1'b0;
            result <= '0;
        end else begin
            if (done) begin
                flag   <= 1'b1;
                result <= sample;
            end else if (flag_clr) begin
                flag <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sar_seq_sel.sv
`timescale 1ns/1ps
module sar_seq_sel #(
    parameter int CHAN_W = 4,
    parameter int REF_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [CHAN_W-1:0] chan_in,
    input  logic [REF_W-1:0]  ref_in,
    input  logic              upd,
    output logic [CHAN_W-1:0] chan_eff,
    output logic [REF_W-1:0]  ref_eff
);
    localparam int SEL_W = CHAN_W + REF_W;

    logic [SEL_W-1:0] pend_q;
    logic [SEL_W-1:0] eff_q;
    logic [SEL_W-1:0] next_sel;

    assign next_sel = wr ? {chan_in, ref_in} : pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            eff_q  <= '0;
        end else begin
            pend_q <= next_sel;
            if (upd) eff_q <= next_sel;
        end
    end

    assign chan_eff = eff_q[SEL_W-1:REF_W];
    assign ref_eff  = eff_q[REF_W-1:0];
endmodule

// File: rtl/sar_seq_ctrl.sv
`timescale 1ns/1ps
module sar_seq_ctrl
    import sar_seq_pkg::*;
#(
    parameter int SMP_W  = 10,
    parameter int CHAN_W = 4,
    parameter int REF_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_wr,
    input  logic [CTL_W-1:0]  ctl_wdata,
    input  logic [DIV_W-1:0]  ctl_div,
    output logic [CTL_W-1:0]  ctl_rdata,
    input  logic              sel_wr,
    input  logic [CHAN_W-1:0] sel_chan,
    input  logic [REF_W-1:0]  sel_ref,
    input  logic              gie,
    input  logic              irq_ack,
    input  logic [SMP_W-1:0]  sample_in,
    output logic              adc_clk,
    output logic [CHAN_W-1:0] eff_chan,
    output logic [REF_W-1:0]  eff_ref,
    output logic [SMP_W-1:0]  result,
    output logic              irq
);
    ctl_t ctl_q;
    logic en_rise;
    logic abort;
    logic start_req;
    logic flag_clr;
    logic tick;
    logic busy;
    logic conv_done;
    logic flag;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else if (ctl_wr) begin
            ctl_q.en   <= ctl_wdata[B_EN];
            ctl_q.loop <= ctl_wdata[B_LOOP];
            ctl_q.ie   <= ctl_wdata[B_IE];
            ctl_q.div  <= ctl_div;
        end
    end

    assign en_rise   = ctl_wr && ctl_wdata[B_EN] && !ctl_q.en;
    assign abort     = ctl_wr && !ctl_wdata[B_EN];
    assign start_req = ctl_wr && ctl_wdata[B_EN] && ctl_wdata[B_GO];
    assign flag_clr  = (ctl_wr && ctl_wdata[B_DONE]) || irq_ack;

    sar_seq_prescaler u_pre (
        .clk     (clk),
        .rst     (rst),
        .run     (ctl_q.en),
        .div_sel (ctl_q.div),
        .tick    (tick),
        .adc_clk (adc_clk)
    );

    sar_seq_engine #(.SMP_W(SMP_W)) u_eng (
        .clk       (clk),
        .rst       (rst),
        .en_rise   (en_rise),
        .start_req (start_req),
        .abort     (abort),
        .loop      (ctl_q.loop),
        .tick      (tick),
        .flag_clr  (flag_clr),
        .sample    (sample_in),
        .busy      (busy),
        .done      (conv_done),
        .flag      (flag),
        .result    (result)
    );

    sar_seq_sel #(.CHAN_W(CHAN_W), .REF_W(REF_W)) u_sel (
        .clk      (clk),
        .rst      (rst),
        .wr       (sel_wr),
        .chan_in  (sel_chan),
        .ref_in   (sel_ref),
        .upd      (!busy || conv_done),
        .chan_eff (eff_chan),
        .ref_eff  (eff_ref)
    );

    always_comb begin
        ctl_rdata         = '0;
        ctl_rdata[B_EN]   = ctl_q.en;
        ctl_rdata[B_GO]   = busy;
        ctl_rdata[B_LOOP] = ctl_q.loop;
        ctl_rdata[B_IE]   = ctl_q.ie;
        ctl_rdata[B_DONE] = flag;
    end

    assign irq = flag && ctl_q.ie && gie;
endmodule

// File: rtl/sar_seq_ctrl_chk.sv
`timescale 1ns/1ps
module sar_seq_ctrl_chk
    import sar_seq_pkg::*;
#(
    parameter int CHAN_W = 4,
    parameter int REF_W  = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              ctl_wr,
    input logic [CTL_W-1:0]  ctl_wdata,
    input logic [CTL_W-1:0]  ctl_rdata,
    input logic              gie,
    input logic              irq_ack,
    input logic              irq,
    input logic [CHAN_W-1:0] eff_chan,
    input logic [REF_W-1:0]  eff_ref,
    input logic              conv_done
);
    AST_OFF_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        !ctl_rdata[B_EN] |-> !ctl_rdata[B_GO]); // R7
    AST_ABORT_KEEPS_FLAG_LOW: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && !ctl_wdata[B_EN] && !ctl_rdata[B_DONE]) |=> !ctl_rdata[B_DONE]); // R7
    AST_DONE_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        conv_done |=> ctl_rdata[B_DONE]); // R8
    AST_FLAG_HELD: assert property (@(posedge clk) disable iff (rst)
        (ctl_rdata[B_DONE] && !irq_ack && !(ctl_wr && ctl_wdata[B_DONE])) |=> ctl_rdata[B_DONE]); // R9
    AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (rst)
        !gie |-> !irq); // R10
    AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (ctl_rdata[B_GO] && !conv_done) |=> ($stable(eff_chan) && $stable(eff_ref))); // R11
    AST_SINGLE_STOPS: assert property (@(posedge clk) disable iff (rst)
        (conv_done && !ctl_rdata[B_LOOP]) |=> !ctl_rdata[B_GO]); // R4
    AST_LOOP_CONTINUES: assert property (@(posedge clk) disable iff (rst)
        (conv_done && ctl_rdata[B_LOOP] && !(ctl_wr && !ctl_wdata[B_EN])) |=> ctl_rdata[B_GO]); // R6
endmodule

bind sar_seq_ctrl sar_seq_ctrl_chk #(.CHAN_W(CHAN_W), .REF_W(REF_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ctl_wr    (ctl_wr),
    .ctl_wdata (ctl_wdata),
    .ctl_rdata (ctl_rdata),
    .gie       (gie),
    .irq_ack   (irq_ack),
    .irq       (irq),
    .eff_chan  (eff_chan),
    .eff_ref   (eff_ref),
    .conv_done (conv_done)
);

// File: tb/sar_seq_ctrl_tb.sv
`timescale 1ns/1ps
module sar_seq_ctrl_tb;
    localparam logic [4:0] EN  = 5'h01;
    localparam logic [4:0] GO  = 5'h02;
    localparam logic [4:0] LP  = 5'h04;
    localparam logic [4:0] IE  = 5'h08;
    localparam logic [4:0] CLR = 5'h10;
    localparam int WATCHDOG = 60000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctl_wr = 1'b0;
    logic [4:0] ctl_wdata = '0;
    logic [2:0] ctl_div = '0;
    logic [4:0] ctl_rdata;
    logic       sel_wr = 1'b0;
    logic [3:0] sel_chan = '0;
    logic [1:0] sel_ref = '0;
    logic       gie = 1'b0;
    logic       irq_ack = 1'b0;
    logic [9:0] sample_in = '0;
    logic       adc_clk;
    logic [3:0] eff_chan;
    logic [1:0] eff_ref;
    logic [9:0] result;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    sar_seq_ctrl u_dut (
        .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_div(ctl_div),
        .ctl_rdata(ctl_rdata), .sel_wr(sel_wr), .sel_chan(sel_chan), .sel_ref(sel_ref),
        .gie(gie), .irq_ack(irq_ack), .sample_in(sample_in), .adc_clk(adc_clk),
        .eff_chan(eff_chan), .eff_ref(eff_ref), .result(result), .irq(irq)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_rng(input string req, input string what, input int act, input int lo, input int hi);
        n_chk++;
        if (act < lo || act > hi) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d..%0d", req, what, act, lo, hi);
        end
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    task automatic wr_ctl(input logic [4:0] b, input logic [2:0] d);
        ctl_wdata = b;
        ctl_div   = d;
        ctl_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        ctl_wr    = 1'b0;
    endtask

    task automatic wr_sel(input logic [3:0] c, input logic [1:0] r);
        sel_chan = c;
        sel_ref  = r;
        sel_wr   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        sel_wr   = 1'b0;
    endtask

    task automatic wait_idle();
        while (ctl_rdata[1]) @(negedge clk);
    endtask

    task automatic wait_flag();
        while (!ctl_rdata[4]) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1", "readback", int'(ctl_rdata), 0);
        chk("R1", "irq", int'(irq), 0);
        chk("R1", "adc_clk", int'(adc_clk), 0);
        chk("R1", "result", int'(result), 0);
        chk("R1", "eff sel", int'({eff_chan, eff_ref}), 0);
    endtask

    // exact first-conversion length for every division code (R2, R3, R12)
    task automatic t_ratios();
        sample_in = 10'h15A;
        for (int d = 0; d < 8; d++) begin
            int t0;
            int n;
            n = (d == 0) ? 2 : (1 << d);
            wr_ctl(5'h00, 3'(d));
            chk("R12", "adc_clk while off", int'(adc_clk), 0);
            wr_ctl(EN | GO, 3'(d));
            t0 = cyc;
            chk("R4", "busy after start", int'(ctl_rdata[1]), 1);
            wait_idle();
            chk("R2", $sformatf("first conversion clocks code %0d", d), cyc - t0, 25 * n);
        end
        chk("R8", "flag after done", int'(ctl_rdata[4]), 1);
        chk("R8", "result", int'(result), 'h15A);
    endtask

    task automatic t_flag_clear();
        wr_ctl(EN, 3'd0);
        chk("R9", "flag kept on write 0", int'(ctl_rdata[4]), 1);
        wr_ctl(EN | CLR, 3'd0);
        chk("R9", "flag cleared by write 1", int'(ctl_rdata[4]), 0);
    endtask

    // later single conversion: 13 cycles, start=0 and start while busy ignored
    task automatic t_single();
        int t0;
        int busy_seen;
        sample_in = 10'h2A5;
        wr_ctl(EN | GO, 3'd3);
        t0 = cyc;
        repeat (4) @(negedge clk);
        wr_ctl(EN, 3'd3);
        chk("R4", "busy kept after start=0 write", int'(ctl_rdata[1]), 1);
        wr_ctl(EN | GO, 3'd3);
        wait_idle();
        chk_rng("R3", "later conversion clocks", cyc - t0, 12 * 8 + 1, 13 * 8);
        chk("R8", "result single", int'(result), 'h2A5);
        busy_seen = 0;
        repeat (40) begin
            @(negedge clk);
            if (ctl_rdata[1]) busy_seen++;
        end
        chk("R5", "no extra conversion", busy_seen, 0);
    endtask

    task automatic t_loop();
        int ta;
        int tb;
        int busy_seen;
        wr_ctl(5'h00, 3'd0);
        wr_ctl(CLR, 3'd0);
        sample_in = 10'h0C3;
        wr_ctl(EN | GO | LP, 3'd0);
        ta = cyc;
        wait_flag();
        chk("R3", "continuous first length", cyc - ta, 50);
        chk("R6", "busy continues", int'(ctl_rdata[1]), 1);
        chk("R8", "result loop 1", int'(result), 'h0C3);
        ta = cyc;
        sample_in = 10'h3E1;
        wr_ctl(EN | LP | CLR, 3'd0);
        wait_flag();
        tb = cyc;
        chk("R6", "back-to-back length", tb - ta, 26);
        chk("R8", "result loop 2", int'(result), 'h3E1);
        wr_ctl(EN, 3'd0);
        chk("R6", "running conversion finishes", int'(ctl_rdata[1]), 1);
        wait_idle();
        chk("R6", "stop after clearing loop", cyc - tb, 26);
        busy_seen = 0;
        repeat (60) begin
            @(negedge clk);
            if (ctl_rdata[1]) busy_seen++;
        end
        chk("R6", "stays stopped", busy_seen, 0);
    endtask

    task automatic t_abort();
        int t0;
        logic [9:0] prev;
        wr_ctl(EN | CLR, 3'd0);
        prev = result;
        wr_ctl(EN | GO, 3'd0);
        repeat (10) @(negedge clk);
        sample_in = 10'h111;
        wr_ctl(5'h00, 3'd0);
        chk("R7", "busy after abort", int'(ctl_rdata[1]), 0);
        repeat (100) @(negedge clk);
        chk("R7", "flag untouched", int'(ctl_rdata[4]), 0);
        chk("R7", "result untouched", int'(result), int'(prev));
        chk("R12", "adc_clk held", int'(adc_clk), 0);
        wr_ctl(EN, 3'd0);
        repeat (7) @(negedge clk);
        wr_ctl(EN | GO, 3'd0);
        t0 = cyc;
        wait_idle();
        chk_rng("R3", "first after separate enable", cyc - t0, 49, 50);
    endtask

    task automatic t_irq();
        gie = 1'b1;
        wr_ctl(EN, 3'd0);
        chk("R10", "irq with ie=0", int'(irq), 0);
        wr_ctl(EN | IE, 3'd0);
        chk("R10", "irq with all set", int'(irq), 1);
        gie = 1'b0;
        #1;
        chk("R10", "irq gated by gie", int'(irq), 0);
        gie = 1'b1;
        irq_ack = 1'b1;
        @(posedge clk);
        @(negedge clk);
        irq_ack = 1'b0;
        chk("R9", "flag cleared by ack", int'(ctl_rdata[4]), 0);
        chk("R10", "irq low after ack", int'(irq), 0);
    endtask

    task automatic t_select();
        wr_sel(4'd5, 2'd3);
        chk("R11", "idle chan applied", int'(eff_chan), 5);
        chk("R11", "idle ref applied", int'(eff_ref), 3);
        wr_ctl(EN | GO, 3'd0);
        repeat (3) @(negedge clk);
        wr_sel(4'd9, 2'd1);
        repeat (2) @(negedge clk);
        chk("R11", "chan held during conversion", int'(eff_chan), 5);
        chk("R11", "ref held during conversion", int'(eff_ref), 3);
        wait_idle();
        chk("R11", "chan after completion", int'(eff_chan), 9);
        chk("R11", "ref after completion", int'(eff_ref), 1);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog (all requirements): actual %0d cycles expected fewer", WATCHDOG);
        report();
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_ratios();
        t_flag_clear();
        t_single();
        t_loop();
        t_abort();
        t_irq();
        t_select();
        report();
        $finish;
    end
endmodule